// File: doc/BRIEF.md
# Word-Addressed Stack Processor Core

A small multi-cycle processor with 16-bit words, eight general registers and a private return/data stack. It reads variable-length instructions (one to four words) from a word-addressed memory with a one-cycle read latency, classifies every operand word by its value range as a literal, a register selector or an illegal value, and runs 22 opcodes covering moves, stack traffic, comparisons, 15-bit arithmetic and logic, branches, subroutine linkage, data memory access and character I/O.

Each instruction passes through opcode fetch, operand fetch, execute and, where needed, a memory-read or I/O wait state. Character output and input use valid/ready handshakes and stall the core until they complete. The core stops for good on a normal halt or on a fault, and shows which through two status outputs that hold until reset.

Top module: `stack_cpu`

## Requirements
- R1: After reset no status output is set, the registers read as 0, and the first cycle drives a fetch (`mem_rd`=1) of word address 0.
- R2: An operand word below 32768 is used as its literal value; 32768 to 32775 select registers R0 to R7 by the low three bits; any operand word of 32776 or more sets `fault`.
- R3: Instructions that write a register (set=1, pop=3, eq=4, gt=5, add=9, mult=10, mod=11, and=12, or=13, not=14, rmem=15, in=20) set `fault` when their first operand is not a register selector.
- R4: Opcode 0 sets `halted`; opcode 21 does nothing; an opcode word above 21 sets `fault`.
- R5: Instruction lengths: 1 word for 0, 18, 21; 2 words for 2, 3, 6, 17, 19, 20; 3 words for 1, 7, 8, 14, 15, 16; 4 words for 4, 5, 9 to 13.
- R6: add and mult keep the low 15 bits of the result; mod gives the remainder; not gives the 15-bit inverse; and/or are bitwise; eq and gt write 1 or 0.
- R7: jmp (6) goes to its operand; jt (7) branches to its second operand when the first is nonzero, jf (8) when it is zero; otherwise execution continues three words on.
- R8: push (2) and pop (3) act as a last-in first-out stack of SDEPTH entries held apart from memory; pop on an empty stack or push on a full one sets `fault`.
- R9: call (17) saves the address of the next instruction on the stack and jumps to its operand; ret (18) pops an address and jumps to it, and sets `halted` when the stack is empty.
- R10: rmem (15) loads a register from the word at its second operand; wmem (16) stores its second operand to the word at its first.
- R11: out (19) raises `out_valid` with the value on `out_data` and holds both unchanged until `out_ready` is seen.
- R12: in (20) raises `in_ready` and waits for `in_valid`, writing `in_data` to the register; the character 0x51 ('Q') sets `halted` instead.
- R13: `halted` and `fault` never rise together, stay set until reset, and no memory access is made while either is set.
- R14: mod with a zero divisor sets `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | AW | Word address for fetch, load or store |
| mem_rd | output | 1 | Read request; data returns the next cycle |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data, one cycle after `mem_rd` |
| out_valid | output | 1 | Output character present |
| out_ready | input | 1 | Output character accepted |
| out_data | output | 16 | Output character value |
| in_valid | input | 1 | Input character present |
| in_ready | output | 1 | Core waits for an input character |
| in_data | input | 8 | Input character value |
| halted | output | 1 | Normal stop |
| fault | output | 1 | Illegal instruction or stack error |

## Verification
The bench targets the branch fall-through distance, where a wrong instruction length lands on a planted halt and loses the expected output, and the operand boundary at 32776, where a core that treats it as a register keeps running and prints. It drives a stack program whose empty-stack return must end in a normal halt rather than a fault, and an add that wraps past 32767 to catch a core that keeps the sixteenth bit. Output is stalled for several cycles to catch a core that drops or changes a character before acceptance, and a 'Q' input must stop the core before the register write and the following output.

// File: rtl/stack_cpu.sv
module stack_cpu #(
  parameter int AW     = 15,
  parameter int SDEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [15:0]   out_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  output logic          halted,
  output logic          fault
);
  localparam int SPW     = $clog2(SDEPTH + 1);
  localparam int SIW     = $clog2(SDEPTH);
  localparam int LAST_OP = 21;

  typedef enum logic [2:0] {
    S_FETCH, S_LATCH, S_EXEC, S_RMEM, S_OUT, S_IN, S_HALT, S_FAULT
  } state_t;

  state_t          state;
  logic [AW-1:0]   pc;
  logic [1:0]      idx;
  logic [4:0]      op;
  logic [15:0]     w1, w2, w3;
  logic [15:0]     regs [8];
  logic [15:0]     stk [SDEPTH];
  logic [SPW-1:0]  sp;

  function automatic logic [1:0] arg_count(input logic [4:0] o);
    case (o)
      5'd0, 5'd18, 5'd21:                        return 2'd0;
      5'd2, 5'd3, 5'd6, 5'd17, 5'd19, 5'd20:     return 2'd1;
      5'd1, 5'd7, 5'd8, 5'd14, 5'd15, 5'd16:     return 2'd2;
      default:                                   return 2'd3;
    endcase
  endfunction

  function automatic logic is_bad(input logic [15:0] w);
    return w >= 16'h8008;
  endfunction

  logic [1:0]     nargs;
  logic [15:0]    v1, v2, v3;
  logic [AW-1:0]  pc_next;
  logic           has_dest, any_bad, dest_err, ok;
  logic           stk_empty, stk_full;
  logic [SPW-1:0] sp_dn;
  logic [15:0]    stk_top;
  logic [31:0]    prod;
  logic [15:0]    rem;
  logic [2:0]     dst;

  assign nargs    = arg_count(op);
  assign v1       = w1[15] ? regs[w1[2:0]] : w1;
  assign v2       = w2[15] ? regs[w2[2:0]] : w2;
  assign v3       = w3[15] ? regs[w3[2:0]] : w3;
  assign dst      = w1[2:0];
  assign pc_next  = pc + AW'(nargs) + AW'(1);
  assign has_dest = (op == 5'd1) || (op == 5'd3) || (op == 5'd4) || (op == 5'd5) ||
                    (op >= 5'd9 && op <= 5'd15) || (op == 5'd20);
  assign any_bad  = (nargs >= 2'd1 && is_bad(w1)) || (nargs >= 2'd2 && is_bad(w2)) ||
                    (nargs == 2'd3 && is_bad(w3));
  assign dest_err = has_dest && !(w1[15] && w1[14:3] == 12'd0);
  assign ok       = !any_bad && !dest_err;
  assign stk_empty = (sp == '0);
  assign stk_full  = (sp == SPW'(SDEPTH));
  assign sp_dn    = sp - 1'b1;
  assign stk_top  = stk[sp_dn[SIW-1:0]];
  assign prod     = v2 * v3;
  assign rem      = (v3 == 16'd0) ? 16'd0 : v2 % v3;

  logic exec_ok;
  assign exec_ok   = (state == S_EXEC) && ok;
  assign mem_rd    = (state == S_FETCH) || (exec_ok && op == 5'd15);
  assign mem_wr    = exec_ok && op == 5'd16;
  assign mem_addr  = (state == S_FETCH) ? pc + AW'(idx) :
                     (op == 5'd15) ? v2[AW-1:0] : v1[AW-1:0];
  assign mem_wdata = v2;
  assign out_valid = (state == S_OUT);
  assign out_data  = v1;
  assign in_ready  = (state == S_IN);
  assign halted    = (state == S_HALT);
  assign fault     = (state == S_FAULT);

  logic        stk_we;
  logic [15:0] stk_wd;
  assign stk_we = exec_ok && ((op == 5'd2) || (op == 5'd17)) && !stk_full;
  assign stk_wd = (op == 5'd2) ? v1 : 16'(pc_next);

  always_ff @(posedge clk)
    if (stk_we) stk[sp[SIW-1:0]] <= stk_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= '0;
      idx   <= '0;
      op    <= '0;
      w1    <= '0;
      w2    <= '0;
      w3    <= '0;
      sp    <= '0;
      for (int i = 0; i < 8; i++) regs[i] <= '0;
    end else begin
      case (state)
        S_FETCH: state <= S_LATCH;
        S_LATCH: begin
          if (idx == 2'd0) begin
            if (mem_rdata > 16'(LAST_OP)) state <= S_FAULT;
            else begin
              op <= mem_rdata[4:0];
              if (arg_count(mem_rdata[4:0]) == 2'd0) state <= S_EXEC;
              else begin
                idx   <= 2'd1;
                state <= S_FETCH;
              end
            end
          end else begin
            case (idx)
              2'd1:    w1 <= mem_rdata;
              2'd2:    w2 <= mem_rdata;
              default: w3 <= mem_rdata;
            endcase
            if (idx == nargs) state <= S_EXEC;
            else begin
              idx   <= idx + 2'd1;
              state <= S_FETCH;
            end
          end
        end
        S_EXEC: begin
          idx <= '0;
          if (!ok) state <= S_FAULT;
          else begin
            pc    <= pc_next;
            state <= S_FETCH;
            case (op)
              5'd0:  state <= S_HALT;
              5'd1:  regs[dst] <= v2;
              5'd2:  if (stk_full) state <= S_FAULT; else sp <= sp + 1'b1;
              5'd3:  if (stk_empty) state <= S_FAULT;
                     else begin regs[dst] <= stk_top; sp <= sp_dn; end
              5'd4:  regs[dst] <= {15'd0, v2 == v3};
              5'd5:  regs[dst] <= {15'd0, v2 > v3};
              5'd6:  pc <= v1[AW-1:0];
              5'd7:  if (v1 != 16'd0) pc <= v2[AW-1:0];
              5'd8:  if (v1 == 16'd0) pc <= v2[AW-1:0];
              5'd9:  regs[dst] <= (v2 + v3) & 16'h7fff;
              5'd10: regs[dst] <= {1'b0, prod[14:0]};
              5'd11: if (v3 == 16'd0) state <= S_FAULT; else regs[dst] <= rem;
              5'd12: regs[dst] <= v2 & v3;
              5'd13: regs[dst] <= v2 | v3;
              5'd14: regs[dst] <= ~v2 & 16'h7fff;
              5'd15: state <= S_RMEM;
              5'd17: if (stk_full) state <= S_FAULT;
                     else begin sp <= sp + 1'b1; pc <= v1[AW-1:0]; end
              5'd18: if (stk_empty) state <= S_HALT;
                     else begin pc <= stk_top[AW-1:0]; sp <= sp_dn; end
              5'd19: state <= S_OUT;
              5'd20: state <= S_IN;
              default: ;
            endcase
          end
        end
        S_RMEM: begin
          regs[dst] <= mem_rdata;
          state     <= S_FETCH;
        end
        S_OUT: if (out_ready) state <= S_FETCH;
        S_IN: if (in_valid) begin
          if (in_data == 8'h51) state <= S_HALT;
          else begin
            regs[dst] <= {8'd0, in_data};
            state     <= S_FETCH;
          end
        end
        default: ;
      endcase
    end
  end

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(halted && fault)); // R13
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted); // R13
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) fault |=> fault); // R13
  AST_QUIET_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) (halted || fault) |-> !mem_rd && !mem_wr); // R13
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> out_valid && $stable(out_data)); // R11
  AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n) sp <= SPW'(SDEPTH)); // R8
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R10
endmodule

// File: tb/tb_stack_cpu.sv
`timescale 1ns/1ps
module tb_stack_cpu;
  localparam int AW = 15;
  localparam int SDEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr;
  logic [15:0] mem_wdata, mem_rdata;
  logic out_valid, out_ready;
  logic [15:0] out_data;
  logic in_valid, in_ready;
  logic [7:0] in_data;
  logic halted, fault;

  stack_cpu #(.AW(AW), .SDEPTH(SDEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .halted(halted), .fault(fault));

  always #2 clk = ~clk;

  logic [15:0] mem [0:1023];
  logic [15:0] outs [$];
  logic [7:0]  inq [$];
  int stall_cfg = 0, stall = 0, hold_viol = 0;
  int errs = 0, checks = 0, wp = 0;
  logic [15:0] held;

  initial begin
    mem_rdata = '0;
    forever begin
      @(posedge clk);
      if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  initial begin
    out_ready = 0; in_valid = 0; in_data = '0;
    forever begin
      @(negedge clk);
      if (out_valid && stall == 0) begin
        if (!out_ready && stall_cfg > 0 && out_data != held) hold_viol++;
        out_ready = 1; outs.push_back(out_data); stall = stall_cfg;
      end else if (out_valid) begin
        if (stall < stall_cfg && out_data != held) hold_viol++;
        held = out_data; out_ready = 0; stall--;
      end else out_ready = 0;
      if (in_valid) in_valid = 0;
      else if (in_ready && inq.size() > 0) begin in_valid = 1; in_data = inq.pop_front(); end
    end
  end

  initial begin
    #400000;
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  function automatic logic [15:0] R(int n); return 16'h8000 + 16'(n); endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 1024; i++) mem[i] = 16'd0;
    wp = 0; outs.delete(); inq.delete(); stall_cfg = 0; stall = 0; hold_viol = 0;
  endtask

  task automatic ins(int n, int a, int b = 0, int c = 0, int d = 0);
    int ws[4];
    ws[0] = a; ws[1] = b; ws[2] = c; ws[3] = d;
    for (int i = 0; i < n; i++) begin mem[wp] = 16'(ws[i]); wp++; end
  endtask

  task automatic start();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run(string tag);
    int n = 0;
    while (!(halted || fault) && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk({tag, " timeout"}, 0, 1);
  endtask

  task automatic chk_outs(string tag, int exp[]);
    chk({tag, " out count"}, outs.size(), exp.size());
    for (int i = 0; i < exp.size() && i < outs.size(); i++) chk({tag, " out value"}, outs[i], exp[i]);
  endtask

  task automatic t_reset();  // R1
    clear_prog();
    ins(2, 19, R(0)); ins(2, 19, R(7)); ins(1, 0);
    start(); #1;
    chk("R1 fetch request", mem_rd, 1);
    chk("R1 fetch address", mem_addr, 0);
    chk("R1 halted low", halted, 0);
    chk("R1 fault low", fault, 0);
    run("R1");
    chk_outs("R1 regs zero", '{0, 0});
    chk("R4 halt opcode", halted, 1);
  endtask

  task automatic t_arith();  // R6 R2
    clear_prog();
    ins(3, 1, R(1), 30000);
    ins(4, 9, R(2), R(1), 5000);
    ins(4, 10, R(3), 300, 200);
    ins(4, 11, R(4), 100, 7);
    ins(3, 14, R(5), 16'h1234);
    ins(4, 12, R(6), 16'h0ff0, 16'h3c3c);
    ins(4, 13, R(7), 16'h0ff0, 16'h3c3c);
    ins(4, 4, R(0), 5, 5);
    ins(4, 5, R(1), 3, 4);
    for (int r = 0; r < 8; r++) ins(2, 19, R(r));
    ins(1, 0);
    start(); run("R6");
    chk_outs("R6 alu", '{1, 0, 2232, 27232, 2, 16'h6dcb, 16'h0c30, 16'h3ffc});
    chk("R6 no fault", fault, 0);
  endtask

  task automatic t_branch();  // R7 R5 R4
    clear_prog();
    ins(3, 7, 0, 9); ins(3, 8, 1, 9); ins(3, 7, 5, 10); ins(1, 0);
    ins(3, 8, 0, 14); ins(1, 0); ins(2, 19, 75); ins(1, 21); ins(2, 19, 76); ins(1, 0);
    start(); run("R7");
    chk_outs("R7 branch and R5 length", '{75, 76});
    chk("R4 noop then halt", halted, 1);
  endtask

  task automatic t_stack();  // R8 R9
    clear_prog();
    ins(2, 2, 11); ins(2, 2, 22); ins(2, 17, 20); ins(2, 3, R(1)); ins(2, 19, R(1));
    ins(2, 3, R(2)); ins(2, 19, R(2)); ins(1, 18);
    wp = 20; ins(2, 19, 33); ins(1, 18);
    start(); run("R9");
    chk_outs("R9 call ret and R8 lifo", '{33, 22, 11});
    chk("R9 empty ret halts", halted, 1);
    chk("R9 empty ret no fault", fault, 0);
  endtask

  task automatic t_stack_err();  // R8
    clear_prog();
    ins(2, 3, R(0)); ins(1, 0);
    start(); run("R8");
    chk("R8 pop empty faults", fault, 1);
    clear_prog();
    ins(2, 2, 1); ins(2, 6, 0);
    start(); run("R8");
    chk("R8 push full faults", fault, 1);
  endtask

  task automatic t_bad_operand();  // R2 R3 R4 R14
    clear_prog();
    ins(2, 19, 32775); ins(2, 19, 32776); ins(1, 0);
    start(); run("R2");
    chk_outs("R2 last register ok", '{0});
    chk("R2 operand 32776 faults", fault, 1);
    clear_prog();
    ins(3, 1, 5, 7); ins(1, 0);
    start(); run("R3");
    chk("R3 literal dest faults", fault, 1);
    clear_prog();
    ins(1, 22);
    start(); run("R4");
    chk("R4 opcode 22 faults", fault, 1);
    clear_prog();
    ins(4, 11, R(0), 9, 0); ins(1, 0);
    start(); run("R14");
    chk("R14 mod zero faults", fault, 1);
  endtask

  task automatic t_mem();  // R10
    clear_prog();
    ins(3, 16, 500, 1234); ins(3, 15, R(3), 500); ins(2, 19, R(3));
    ins(3, 1, R(4), 501); ins(3, 16, R(4), R(3)); ins(1, 0);
    start(); run("R10");
    chk_outs("R10 load", '{1234});
    chk("R10 store literal addr", mem[500], 1234);
    chk("R10 store register addr", mem[501], 1234);
  endtask

  task automatic t_out_stall();  // R11
    clear_prog();
    ins(2, 19, 65); ins(2, 19, 66); ins(1, 0);
    stall_cfg = 5; stall = 5;
    start(); run("R11");
    chk_outs("R11 stalled output", '{65, 66});
    chk("R11 data held while stalled", hold_viol, 0);
  endtask

  task automatic t_input();  // R12
    clear_prog();
    ins(2, 20, R(2)); ins(2, 19, R(2)); ins(2, 20, R(3)); ins(2, 19, R(3)); ins(1, 0);
    inq.push_back(8'h61); inq.push_back(8'h62);
    start(); run("R12");
    chk_outs("R12 input echo", '{97, 98});
    clear_prog();
    ins(2, 20, R(2)); ins(2, 19, 1); ins(1, 0);
    inq.push_back(8'h51);
    start(); run("R12");
    chk("R12 Q halts", halted, 1);
    chk("R12 Q no further output", outs.size(), 0);
  endtask

  task automatic t_sticky();  // R13
    int quiet = 1;
    clear_prog();
    ins(1, 0);
    start(); run("R13");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (mem_rd || mem_wr || !halted || fault) quiet = 0;
    end
    chk("R13 stays halted and quiet", quiet, 1);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_branch();
    t_stack();
    t_stack_err();
    t_bad_operand();
    t_mem();
    t_out_stall();
    t_input();
    t_sticky();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule